// File: doc/BRIEF.md
# Paged Memory Chip-Select Decoder

This block turns each bus cycle of an 8051-class core into chip selects and output enables for the memories around it. The core has separate program and data spaces, told apart by active-low strobes: one for program fetch, one for data read, one for data write. The decoder looks at the 16-bit address, the strobes, a power-down input and two internal byte registers. One register selects the page. The other, the space-control register, says which memories may answer fetches and which may answer data reads. The decoder then selects one of eight banked main-flash sectors, four secondary-flash sectors, an SRAM, a control-register window or a peripheral I/O window.

The regions overlap on purpose. A fixed priority picks one target per cycle: SRAM first, then the control window and peripheral I/O, then secondary flash, then main flash. The secondary flash is a common area that ignores the page. The main-flash sectors all share the upper 32 KB, and the low page bits choose among them. Software can rewrite the space-control register at run time. This lets the two flash arrays swap program and data roles, so one array can run update code while the other is erased and rewritten.

Chip-select and output-enable outputs are active high. The two registers are written by ordinary data writes into the control window and take effect from the next cycle.

Top module: `paged_cs_decoder`

## Requirements
- R1: After reset the space-control register holds 0x0C and the page register holds 0x00. Main flash therefore answers fetches only, and secondary flash answers data reads only.
- R2: An address from 0x8000 to 0xFFFF selects main-flash sector k (main_cs bit k), where k is the page register's low three bits. Page bits 7..3 have no effect on this choice.
- R3: An address from 0x0000 to 0x7FFF that no higher-priority region claims selects secondary-flash sector addr[14:13] (sec_cs bit addr[14:13]). The page value has no effect.
- R4: Addresses 0x0000 to 0x1FFF select SRAM (sram_cs), which wins over secondary flash.
- R5: Addresses 0x7F00 to 0x7FFF select the control window (ctl_cs), which wins over secondary flash.
- R6: Addresses 0x7E00 to 0x7EFF select peripheral I/O (pio_cs) only when space-control bit 7 is 1 and the fetch strobe is high. Otherwise the address falls through to secondary-flash sector 3.
- R7: An output enable is high only when its chip select is high and an allowed strobe is low. Main flash may use fetch if space-control bit 2 is set, and read if bit 4 is set. Secondary flash may use fetch if bit 1 is set, and read if bit 3 is set. SRAM always may use read, and may use fetch if bit 0 is set.
- R8: While pdn is 1, every chip select and output enable is 0, and writes to the control window are ignored.
- R9: A write strobe with address 0x7F00 loads the whole space-control byte, and address 0x7F01 loads the whole page byte, both visible from the next cycle. Writes to other control-window offsets change neither register.
- R10: At most one chip select is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Bus address |
| rd_n | input | 1 | Data read strobe, active low |
| psen_n | input | 1 | Program fetch strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| wdata | input | 8 | Write data for the control registers |
| pdn | input | 1 | Power-down, blocks all decoding when 1 |
| main_cs | output | 8 | Main-flash sector chip selects |
| main_oe | output | 8 | Main-flash sector output enables |
| sec_cs | output | 4 | Secondary-flash sector chip selects |
| sec_oe | output | 4 | Secondary-flash sector output enables |
| sram_cs | output | 1 | SRAM chip select |
| sram_oe | output | 1 | SRAM output enable |
| ctl_cs | output | 1 | Control-register window select |
| pio_cs | output | 1 | Peripheral I/O window select |

## Verification
The decoder is driven with fetches, reads and writes at the edges of each region, under several page values and space-control settings.

- Edge addresses show whether overlaps resolve by priority: 0x1FFF against 0x2000, and 0x7DFF, 0x7E10 and 0x7F00 against sector 3.
- Pages 5 and 0x0B show that only the low page bits select a main sector.
- Space-control values 0x0C, 0x16 and 0x17 exercise every output-enable gate against both strobes.
- Setting bit 7 and toggling the fetch strobe shows that the I/O window opens only on data accesses.

A final sweep covers the whole address space under mixed register values, checking every select against an independent model and checking that at most one select is ever high.

// File: rtl/pcd_pkg.sv
// Package: shared constants and helpers for the paged chip-select decoder.
// Assumes a 16-bit address bus and byte-wide control registers.
package pcd_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Space-control bit positions; neighbouring software depends on them.
    localparam int SPC_SRAM_PROG = 0;
    localparam int SPC_SEC_PROG  = 1;
    localparam int SPC_MAIN_PROG = 2;
    localparam int SPC_SEC_DATA  = 3;
    localparam int SPC_MAIN_DATA = 4;
    localparam int SPC_PIO_EN    = 7;

    // Gating bits taken from the space-control register.
    typedef struct packed {
        logic sram_prog;
        logic sec_prog;
        logic main_prog;
        logic sec_data;
        logic main_data;
    } space_gate_t;

    // Inclusive address window test.
    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] lo,
                                       input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction
endpackage

// File: rtl/pcd_ctrl_regs.sv
// Module: space-control and page registers, written as whole bytes.
// Assumes wr_hit already folds in the write strobe, power-down and the
// control-window match; off is the address offset inside that window.
module pcd_ctrl_regs
    import pcd_pkg::*;
#(
    parameter int                OFF_W     = 8,
    parameter logic [OFF_W-1:0]  SPACE_OFF = '0,
    parameter logic [OFF_W-1:0]  PAGE_OFF  = OFF_W'(1),
    parameter logic [DATA_W-1:0] SPACE_RST = 8'h0C,
    parameter logic [DATA_W-1:0] PAGE_RST  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] space_q,
    output logic [DATA_W-1:0] page_q
);
    logic space_we;
    logic page_we;

    // Purpose: pick which register a control-window write targets.
    always_comb begin
        space_we = wr_hit && (off == SPACE_OFF);
        page_we  = wr_hit && (off == PAGE_OFF);
    end

    // Purpose: hold the space-control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        space_q <= SPACE_RST;
        else if (space_we) space_q <= wdata;
    end

    // Purpose: hold the page byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= PAGE_RST;
        else if (page_we) page_q <= wdata;
    end
endmodule

// File: rtl/pcd_region_match.sv
// Module: raw address-window matches for every region, before priority.
// Assumes live is low during power-down; main sectors share one window and
// are told apart by the low page bits, secondary sectors split their
// window into equal slices.
module pcd_region_match
    import pcd_pkg::*;
#(
    parameter int                MAIN_N    = 8,
    parameter int                SEC_N     = 4,
    parameter int                PAGE_BITS = 3,
    parameter logic [ADDR_W-1:0] MAIN_LO   = 16'h8000,
    parameter logic [ADDR_W-1:0] MAIN_HI   = 16'hFFFF,
    parameter logic [ADDR_W-1:0] SEC_LO    = 16'h0000,
    parameter logic [ADDR_W-1:0] SEC_HI    = 16'h7FFF,
    parameter logic [ADDR_W-1:0] SRAM_LO   = 16'h0000,
    parameter logic [ADDR_W-1:0] SRAM_HI   = 16'h1FFF,
    parameter logic [ADDR_W-1:0] CTL_LO    = 16'h7F00,
    parameter logic [ADDR_W-1:0] CTL_HI    = 16'h7FFF,
    parameter logic [ADDR_W-1:0] PIO_LO    = 16'h7E00,
    parameter logic [ADDR_W-1:0] PIO_HI    = 16'h7EFF
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [PAGE_BITS-1:0] page_lo,
    input  logic                 live,
    input  logic                 pio_en,
    input  logic                 fetch,
    output logic [MAIN_N-1:0]    main_hit,
    output logic [SEC_N-1:0]     sec_hit,
    output logic                 sram_hit,
    output logic                 ctl_hit,
    output logic                 pio_hit
);
    localparam int SEC_SPAN = (int'(SEC_HI) - int'(SEC_LO) + 1) / SEC_N;

    logic in_main;

    // Purpose: single-window regions and the shared main window.
    always_comb begin
        in_main  = live && in_window(addr, MAIN_LO, MAIN_HI);
        sram_hit = live && in_window(addr, SRAM_LO, SRAM_HI);
        ctl_hit  = live && in_window(addr, CTL_LO, CTL_HI);
        pio_hit  = live && pio_en && !fetch && in_window(addr, PIO_LO, PIO_HI);
    end

    // One comparator per banked main sector.
    for (genvar k = 0; k < MAIN_N; k++) begin : g_main
        assign main_hit[k] = in_main && (page_lo == PAGE_BITS'(k));
    end

    // One window per common-area sector.
    for (genvar j = 0; j < SEC_N; j++) begin : g_sec
        localparam int LO = int'(SEC_LO) + j * SEC_SPAN;
        localparam int HI = LO + SEC_SPAN - 1;
        assign sec_hit[j] = live && in_window(addr, ADDR_W'(LO), ADDR_W'(HI));
    end
endmodule

// File: rtl/pcd_resolve.sv
// Module: fixed-priority resolution and output-enable gating.
// Priority order: SRAM, then control/peripheral windows (disjoint), then
// secondary flash, then main flash. Output enables need the chip select
// and a strobe the space-control gates allow.
module pcd_resolve
    import pcd_pkg::*;
#(
    parameter int MAIN_N = 8,
    parameter int SEC_N  = 4
) (
    input  logic [MAIN_N-1:0] main_hit,
    input  logic [SEC_N-1:0]  sec_hit,
    input  logic              sram_hit,
    input  logic              ctl_hit,
    input  logic              pio_hit,
    input  space_gate_t       gate,
    input  logic              rd,
    input  logic              fetch,
    output logic [MAIN_N-1:0] main_cs,
    output logic [MAIN_N-1:0] main_oe,
    output logic [SEC_N-1:0]  sec_cs,
    output logic [SEC_N-1:0]  sec_oe,
    output logic              sram_cs,
    output logic              sram_oe,
    output logic              ctl_cs,
    output logic              pio_cs
);
    logic block_mid;
    logic block_sec;
    logic block_main;
    logic main_strobe;
    logic sec_strobe;

    // Purpose: build blocking terms from higher-priority claims.
    always_comb begin
        block_mid  = sram_hit;
        block_sec  = sram_hit || ctl_hit || pio_hit;
        block_main = block_sec || (|sec_hit);
    end

    // Purpose: strobe permission per memory family.
    always_comb begin
        main_strobe = (fetch && gate.main_prog) || (rd && gate.main_data);
        sec_strobe  = (fetch && gate.sec_prog)  || (rd && gate.sec_data);
    end

    // Purpose: single-target selects and SRAM enable.
    always_comb begin
        sram_cs = sram_hit;
        ctl_cs  = ctl_hit && !block_mid;
        pio_cs  = pio_hit && !block_mid;
        sram_oe = sram_cs && (rd || (fetch && gate.sram_prog));
    end

    for (genvar j = 0; j < SEC_N; j++) begin : g_sec
        assign sec_cs[j] = sec_hit[j] && !block_sec;
        assign sec_oe[j] = sec_cs[j] && sec_strobe;
    end

    for (genvar k = 0; k < MAIN_N; k++) begin : g_main
        assign main_cs[k] = main_hit[k] && !block_main;
        assign main_oe[k] = main_cs[k] && main_strobe;
    end
endmodule

// File: rtl/paged_cs_decoder.sv
// Module: top of the paged chip-select decoder.
// Assumes the control window is aligned to its own size, so the low
// address bits form the register offset. All outputs are combinational
// from the bus inputs and the two registers; registers change on clk.
module paged_cs_decoder
    import pcd_pkg::*;
#(
    parameter int                MAIN_N    = 8,
    parameter int                SEC_N     = 4,
    parameter int                PAGE_BITS = 3,
    parameter logic [ADDR_W-1:0] MAIN_LO   = 16'h8000,
    parameter logic [ADDR_W-1:0] MAIN_HI   = 16'hFFFF,
    parameter logic [ADDR_W-1:0] SEC_LO    = 16'h0000,
    parameter logic [ADDR_W-1:0] SEC_HI    = 16'h7FFF,
    parameter logic [ADDR_W-1:0] SRAM_LO   = 16'h0000,
    parameter logic [ADDR_W-1:0] SRAM_HI   = 16'h1FFF,
    parameter logic [ADDR_W-1:0] CTL_LO    = 16'h7F00,
    parameter logic [ADDR_W-1:0] CTL_HI    = 16'h7FFF,
    parameter logic [ADDR_W-1:0] PIO_LO    = 16'h7E00,
    parameter logic [ADDR_W-1:0] PIO_HI    = 16'h7EFF,
    parameter logic [DATA_W-1:0] SPACE_RST = 8'h0C,
    parameter logic [DATA_W-1:0] PAGE_RST  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic              rd_n,
    input  logic              psen_n,
    input  logic              wr_n,
    input  logic [7:0]        wdata,
    input  logic              pdn,
    output logic [MAIN_N-1:0] main_cs,
    output logic [MAIN_N-1:0] main_oe,
    output logic [SEC_N-1:0]  sec_cs,
    output logic [SEC_N-1:0]  sec_oe,
    output logic              sram_cs,
    output logic              sram_oe,
    output logic              ctl_cs,
    output logic              pio_cs
);
    localparam int CTL_SPAN = int'(CTL_HI) - int'(CTL_LO) + 1;
    localparam int OFF_W    = $clog2(CTL_SPAN);

    logic              live;
    logic              rd;
    logic              fetch;
    logic              wr_hit;
    logic [DATA_W-1:0] space_q;
    logic [DATA_W-1:0] page_q;
    space_gate_t       gate;
    logic [MAIN_N-1:0] main_hit;
    logic [SEC_N-1:0]  sec_hit;
    logic              sram_hit;
    logic              ctl_hit;
    logic              pio_hit;
    logic              unused_bits;

    // Purpose: internal active-high strobes and the register write enable.
    always_comb begin
        live   = !pdn;
        rd     = !rd_n;
        fetch  = !psen_n;
        wr_hit = live && !wr_n && in_window(addr, CTL_LO, CTL_HI);
    end

    // Purpose: unpack the space-control gating bits.
    always_comb begin
        gate.sram_prog = space_q[SPC_SRAM_PROG];
        gate.sec_prog  = space_q[SPC_SEC_PROG];
        gate.main_prog = space_q[SPC_MAIN_PROG];
        gate.sec_data  = space_q[SPC_SEC_DATA];
        gate.main_data = space_q[SPC_MAIN_DATA];
    end

    // Upper page bits are logic inputs for other decode terms, unused here.
    assign unused_bits = ^{page_q[DATA_W-1:PAGE_BITS], space_q[6:5]};

    pcd_ctrl_regs #(
        .OFF_W     (OFF_W),
        .SPACE_OFF (OFF_W'(0)),
        .PAGE_OFF  (OFF_W'(1)),
        .SPACE_RST (SPACE_RST),
        .PAGE_RST  (PAGE_RST)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .off     (addr[OFF_W-1:0]),
        .wdata   (wdata),
        .space_q (space_q),
        .page_q  (page_q)
    );

    pcd_region_match #(
        .MAIN_N    (MAIN_N),
        .SEC_N     (SEC_N),
        .PAGE_BITS (PAGE_BITS),
        .MAIN_LO   (MAIN_LO),
        .MAIN_HI   (MAIN_HI),
        .SEC_LO    (SEC_LO),
        .SEC_HI    (SEC_HI),
        .SRAM_LO   (SRAM_LO),
        .SRAM_HI   (SRAM_HI),
        .CTL_LO    (CTL_LO),
        .CTL_HI    (CTL_HI),
        .PIO_LO    (PIO_LO),
        .PIO_HI    (PIO_HI)
    ) match_i (
        .addr     (addr),
        .page_lo  (page_q[PAGE_BITS-1:0]),
        .live     (live),
        .pio_en   (space_q[SPC_PIO_EN]),
        .fetch    (fetch),
        .main_hit (main_hit),
        .sec_hit  (sec_hit),
        .sram_hit (sram_hit),
        .ctl_hit  (ctl_hit),
        .pio_hit  (pio_hit)
    );

    pcd_resolve #(
        .MAIN_N (MAIN_N),
        .SEC_N  (SEC_N)
    ) resolve_i (
        .main_hit (main_hit),
        .sec_hit  (sec_hit),
        .sram_hit (sram_hit),
        .ctl_hit  (ctl_hit),
        .pio_hit  (pio_hit),
        .gate     (gate),
        .rd       (rd),
        .fetch    (fetch),
        .main_cs  (main_cs),
        .main_oe  (main_oe),
        .sec_cs   (sec_cs),
        .sec_oe   (sec_oe),
        .sram_cs  (sram_cs),
        .sram_oe  (sram_oe),
        .ctl_cs   (ctl_cs),
        .pio_cs   (pio_cs)
    );
endmodule

// File: rtl/paged_cs_decoder_chk.sv
// Module: property checker bound to the decoder top.
// Assumes default region map; observes ports plus the two registers.
module paged_cs_decoder_chk #(
    parameter int MAIN_N = 8,
    parameter int SEC_N  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       addr,
    input logic              rd_n,
    input logic              psen_n,
    input logic              wr_n,
    input logic [7:0]        wdata,
    input logic              pdn,
    input logic [MAIN_N-1:0] main_cs,
    input logic [MAIN_N-1:0] main_oe,
    input logic [SEC_N-1:0]  sec_cs,
    input logic [SEC_N-1:0]  sec_oe,
    input logic              sram_cs,
    input logic              sram_oe,
    input logic              ctl_cs,
    input logic              pio_cs,
    input logic [7:0]        space_q,
    input logic [7:0]        page_q
);
    logic [MAIN_N+SEC_N+2:0] all_cs;
    logic                    ctl_wr;

    // Purpose: gather selects and flag qualified control writes.
    always_comb begin
        all_cs = {pio_cs, ctl_cs, sram_cs, sec_cs, main_cs};
        ctl_wr = !pdn && !wr_n && (addr[15:8] == 8'h7F);
    end

    assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(all_cs));

    assert_pdn_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |-> (all_cs == '0) && (main_oe == '0) && (sec_oe == '0) && !sram_oe);

    assert_oe_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((main_oe & ~main_cs) == '0) && ((sec_oe & ~sec_cs) == '0) && (!sram_oe || sram_cs));

    assert_pio_data_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pio_cs |-> (psen_n && space_q[7]));

    assert_sram_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && addr < 16'h2000) |-> sram_cs);

    assert_page_sector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && addr[15]) |-> main_cs[page_q[2:0]]);

    assert_page_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && addr[7:0] == 8'h01) |=> (page_q == $past(wdata)));

    assert_space_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && addr[7:0] == 8'h00) |=> (space_q == $past(wdata)));

    assert_fetch_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|main_oe && rd_n) |-> space_q[2]);
endmodule

bind paged_cs_decoder paged_cs_decoder_chk #(.MAIN_N(MAIN_N), .SEC_N(SEC_N)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_n    (rd_n),
    .psen_n  (psen_n),
    .wr_n    (wr_n),
    .wdata   (wdata),
    .pdn     (pdn),
    .main_cs (main_cs),
    .main_oe (main_oe),
    .sec_cs  (sec_cs),
    .sec_oe  (sec_oe),
    .sram_cs (sram_cs),
    .sram_oe (sram_oe),
    .ctl_cs  (ctl_cs),
    .pio_cs  (pio_cs),
    .space_q (space_q),
    .page_q  (page_q)
);

// File: tb/paged_cs_decoder_tb_top.sv
// Scoreboard bench: the driver pushes expected selects and enables,
// the monitor pops and compares them between clock edges.
module paged_cs_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic        rd_n, psen_n, wr_n, pdn;
    logic [7:0]  wdata;
    logic [7:0]  main_cs, main_oe;
    logic [3:0]  sec_cs, sec_oe;
    logic        sram_cs, sram_oe, ctl_cs, pio_cs;

    typedef struct {
        logic [14:0] cs;
        logic [12:0] oe;
        string       tag;
    } item_t;

    item_t      sb_q[$];
    int         checks = 0;
    int         errors = 0;
    logic [7:0] m_spc, m_pg;
    event       go;

    always #4 clk = ~clk;

    paged_cs_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .psen_n(psen_n),
        .wr_n(wr_n), .wdata(wdata), .pdn(pdn), .main_cs(main_cs), .main_oe(main_oe),
        .sec_cs(sec_cs), .sec_oe(sec_oe), .sram_cs(sram_cs), .sram_oe(sram_oe),
        .ctl_cs(ctl_cs), .pio_cs(pio_cs)
    );

    // Expected selects from the requirements: [7:0] main, [11:8] sec,
    // [12] sram, [13] ctl, [14] pio.
    function automatic logic [14:0] model_cs(input logic [15:0] a, input logic p_n,
                                             input logic pd, input logic [7:0] spc,
                                             input logic [7:0] pg);
        logic [14:0] r = '0;
        if (pd) return r;
        if (a <= 16'h1FFF)                           r[12] = 1'b1;       // R4
        else if (a >= 16'h7F00 && a <= 16'h7FFF)     r[13] = 1'b1;       // R5
        else if (a >= 16'h7E00 && a <= 16'h7EFF && p_n && spc[7])
                                                     r[14] = 1'b1;       // R6
        else if (a < 16'h8000)                       r[8 + a[14:13]] = 1'b1; // R3
        else                                         r[pg[2:0]] = 1'b1;  // R2
        return r;
    endfunction

    // Expected enables from R7.
    function automatic logic [12:0] model_oe(input logic [14:0] c, input logic r_n,
                                             input logic p_n, input logic [7:0] spc);
        logic m_ok = (!p_n && spc[2]) || (!r_n && spc[4]);
        logic s_ok = (!p_n && spc[1]) || (!r_n && spc[3]);
        logic r_ok = !r_n || (!p_n && spc[0]);
        return {c[12] & r_ok, c[11:8] & {4{s_ok}}, c[7:0] & {8{m_ok}}};
    endfunction

    task automatic drive(input logic [15:0] a, input logic r_n, input logic p_n,
                         input logic w_n, input logic [7:0] d, input logic pd,
                         input string tag);
        item_t it;
        @(negedge clk);
        addr = a; rd_n = r_n; psen_n = p_n; wr_n = w_n; wdata = d; pdn = pd;
        it.cs  = model_cs(a, p_n, pd, m_spc, m_pg);
        it.oe  = model_oe(it.cs, r_n, p_n, m_spc);
        it.tag = tag;
        sb_q.push_back(it);
        -> go;
        // R9: registers load on the coming edge when the write qualifies.
        if (!w_n && !pd && a == 16'h7F00) m_spc = d;
        if (!w_n && !pd && a == 16'h7F01) m_pg  = d;
    endtask

    // Monitor: compare outputs 2 ns after the driver, before the next edge.
    initial begin
        forever begin
            item_t it;
            logic [14:0] got_cs;
            logic [12:0] got_oe;
            @(go);
            #2;
            it     = sb_q.pop_front();
            got_cs = {pio_cs, ctl_cs, sram_cs, sec_cs, main_cs};
            got_oe = {sram_oe, sec_oe, main_oe};
            checks++;
            if (got_cs !== it.cs) begin
                errors++;
                $display("FAIL %s cs actual=%h expected=%h", it.tag, got_cs, it.cs);
            end
            checks++;
            if (got_oe !== it.oe) begin
                errors++;
                $display("FAIL %s oe actual=%h expected=%h", it.tag, got_oe, it.oe);
            end
            checks++;
            if ($countones(got_cs) > 1) begin
                errors++;
                $display("FAIL R10 multiple selects actual=%h expected=at most one", got_cs);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        addr = '0; rd_n = 1; psen_n = 1; wr_n = 1; wdata = '0; pdn = 0;
        rst_n = 0; m_spc = 8'h0C; m_pg = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        drive(16'h8000, 1, 0, 1, 0, 0, "R1 reset fetch main0 enabled");
        drive(16'h8000, 0, 1, 1, 0, 0, "R1 reset read main0 not enabled");
        drive(16'h2000, 0, 1, 1, 0, 0, "R1 reset read sec1 enabled");
        drive(16'h2000, 1, 0, 1, 0, 0, "R1 reset fetch sec1 not enabled");

        drive(16'h7F01, 1, 1, 0, 8'h05, 0, "R9 page write hits ctl R5");
        drive(16'hC000, 1, 0, 1, 0, 0, "R2 page 5 main5");
        drive(16'h7F01, 1, 1, 0, 8'h0B, 0, "R9 page write 0x0B");
        drive(16'hFFFF, 1, 0, 1, 0, 0, "R2 upper page bits ignored");
        drive(16'h6000, 0, 1, 1, 0, 0, "R3 sec3 independent of page");
        drive(16'h1FFF, 0, 1, 1, 0, 0, "R4 sram top");
        drive(16'h0000, 1, 0, 1, 0, 0, "R4 sram fetch not enabled");
        drive(16'h7F80, 0, 1, 1, 0, 0, "R5 ctl window");
        drive(16'h7E10, 0, 1, 1, 0, 0, "R6 pio off falls to sec3");

        drive(16'h7F00, 1, 1, 0, 8'h8C, 0, "R9 space write 0x8C");
        drive(16'h7E10, 0, 1, 1, 0, 0, "R6 pio on data read");
        drive(16'h7E10, 1, 0, 1, 0, 0, "R6 pio blocked on fetch");
        drive(16'h7EFF, 0, 1, 1, 0, 0, "R6 pio top");
        drive(16'h7DFF, 0, 1, 1, 0, 0, "R6 below pio is sec3");
        drive(16'h7F00, 0, 1, 1, 0, 0, "R5 ctl base");

        drive(16'h7F00, 1, 1, 0, 8'h16, 0, "R9 space write 0x16");
        drive(16'h9000, 0, 1, 1, 0, 0, "R7 main data enabled");
        drive(16'h9000, 1, 0, 1, 0, 0, "R7 main fetch enabled");
        drive(16'h4000, 1, 0, 1, 0, 0, "R7 sec fetch enabled");
        drive(16'h4000, 0, 1, 1, 0, 0, "R7 sec read not enabled");
        drive(16'h7F00, 1, 1, 0, 8'h17, 0, "R9 space write 0x17");
        drive(16'h0100, 1, 0, 1, 0, 0, "R7 sram fetch enabled");

        drive(16'h8000, 1, 0, 1, 0, 1, "R8 pdn no select");
        drive(16'h7F01, 1, 1, 0, 8'h02, 1, "R8 pdn write ignored");
        drive(16'h8000, 1, 0, 1, 0, 0, "R8 page kept after pdn write");
        drive(16'h7F02, 1, 1, 0, 8'hFF, 0, "R9 other offset write");
        drive(16'h7E10, 0, 1, 1, 0, 0, "R9 space unchanged by other offset");
        drive(16'h8000, 1, 0, 1, 0, 0, "R9 page unchanged by other offset");

        for (int v = 0; v < 2; v++) begin
            for (int g = 0; g < 2; g++) begin
                drive(16'h7F00, 1, 1, 0, (v == 0) ? 8'h0C : 8'h9F, 0, "R9 sweep space");
                drive(16'h7F01, 1, 1, 0, (g == 0) ? 8'h00 : 8'hF7, 0, "R9 sweep page");
                for (int a = 0; a < 65536; a += 64) begin
                    drive(16'(a), 0, 1, 1, 0, 0, "R10 sweep read");
                    drive(16'(a + 37), 1, 0, 1, 0, 0, "R10 sweep fetch");
                end
            end
        end

        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule